// File: doc/BRIEF.md
# I2C-to-SPI Bridge Command Decoder

This block sits between an I2C target front-end and an SPI shift engine. The front-end hands it framed bytes: a start marker with a direction bit, one-cycle byte strobes, and a stop marker. In a write frame, the first byte is a command. One command loads a settings word and a chip-select mask. The other command forwards the rest of the frame, byte by byte, to the SPI engine. In a read frame, each byte strobe asks for the next byte that the SPI engine captured. The block answers with captured data up to a read length held in the settings word, and with 0xFF beyond that length.

The configuration registers change only when a well-formed configuration frame closes with a stop. A frame that is too short, too long, or that carries an unknown command raises a one-cycle error pulse and leaves the configuration untouched. The SPI engine is given the chip-select lines and a release-at-end bit straight from the committed settings.

Top module: `bridge_cmd_decoder`

## Requirements
- R1: After reset, `cfg_settings` and `cs_sel` are zero, `cs_release` is 0, `rd_data` is 0xFF, and `spi_tx_vld`, `cfg_update` and `frame_err` are low.
- R2: In a write frame whose command byte is 0x04, each following byte appears on `spi_tx_data` with `spi_tx_vld` high for exactly one cycle, in the cycle after its byte strobe, in arrival order.
- R3: A 0x04 frame forwards at most 62 payload bytes. Later bytes are dropped, and the stop of such a frame pulses `frame_err`. A frame with exactly 62 payload bytes gives no error.
- R4: A 0x03 frame with exactly four bytes after the command commits at its stop. Bytes one and two form `cfg_settings` (high byte first). Bytes three and four form `cs_sel` (high byte first). Both outputs and a one-cycle `cfg_update` pulse appear in the cycle after the stop.
- R5: A 0x03 frame with three or five bytes after the command pulses `frame_err` after its stop. It gives no `cfg_update` and leaves `cfg_settings` and `cs_sel` unchanged.
- R6: A write frame with any command byte other than 0x03 or 0x04 forwards nothing, pulses `frame_err` after its stop, and changes no configuration.
- R7: The configuration outputs keep their old value until the stop strobe. A new start that arrives before the stop abandons a pending configuration frame, with no commit and no error.
- R8: In a read frame, the k-th byte strobe returns on `rd_data`, in the next cycle, the k-th byte that the SPI engine captured through `cap_vld` since the last configuration commit.
- R9: A read request whose index is at or beyond the read length in `cfg_settings[15:10]` returns 0xFF.
- R10: `cs_sel[i]` high marks select line i as active. `cs_release` equals `cfg_settings[5]`: 1 means the engine releases the selects at the end of the transfer, and 0 means it holds them.
- R11: A frame with no bytes, or with only the 0x04 command byte, gives neither an error nor any SPI output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fe_start | input | 1 | Frame start strobe from the I2C front-end |
| fe_stop | input | 1 | Frame stop strobe |
| fe_rnw | input | 1 | Direction, sampled with `fe_start`: 1 means a read frame |
| fe_byte_vld | input | 1 | Byte strobe: a write byte, or a read request in a read frame |
| fe_wdata | input | 8 | Write byte from the host |
| rd_data | output | 8 | Byte returned for the last read request |
| spi_tx_vld | output | 1 | Payload byte valid toward the SPI engine |
| spi_tx_data | output | 8 | Payload byte toward the SPI engine |
| cap_vld | input | 1 | SPI engine captured a byte |
| cap_data | input | 8 | Captured byte |
| cfg_settings | output | 16 | Committed settings word |
| cs_sel | output | 16 | Committed chip-select mask, 1 = active |
| cs_release | output | 1 | Release selects at end of transfer |
| cfg_update | output | 1 | One-cycle pulse after a commit |
| frame_err | output | 1 | One-cycle pulse after a malformed frame ends |

## Verification
Each result of this block comes one register after its cause. A forwarded SPI byte appears in the cycle after its write strobe. A read byte appears in the cycle after its request strobe. The committed configuration, `cfg_update` and `frame_err` all appear in the cycle after the stop strobe. The bench drives each strobe for one cycle just after a rising edge and reads the level outputs one edge later. A monitor on the falling edge logs every `spi_tx_vld`, `cfg_update` and `frame_err` pulse, so the bench can compare counts and byte order once each frame has settled. The configuration is also read before the stop, which shows that nothing commits early.

// File: rtl/bcd_pkg.sv
// Shared constants and types for the bridge command decoder.
// Assumes byte-wide front-end data.
package bcd_pkg;
    localparam logic [7:0] CMD_CONFIG = 8'h03;
    localparam logic [7:0] CMD_WRITE  = 8'h04;
    localparam logic [7:0] FILL_BYTE  = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_CFG,
        ST_WR,
        ST_BAD,
        ST_READ
    } frame_st_e;
endpackage

// File: rtl/bcd_frame_ctl.sv
// Frame controller: tracks the current frame, decodes the command byte,
// counts payload bytes (saturating one past the limit) and produces the
// commit, error, forward and read-request strobes.
// Assumes start, stop and byte strobes do not coincide; if they do,
// start wins over stop, and stop wins over byte.
module bcd_frame_ctl
    import bcd_pkg::*;
#(
    parameter int MAX_PAY   = 62,
    parameter int CFG_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fe_start,
    input  logic       fe_stop,
    input  logic       fe_rnw,
    input  logic       fe_byte_vld,
    input  logic [7:0] fe_wdata,
    output logic       cfg_byte_vld,
    output logic       cfg_commit,
    output logic       rd_start,
    output logic       rd_req,
    output logic       tx_vld,
    output logic [7:0] tx_data,
    output logic       frame_err
);
    localparam int CW = $clog2(MAX_PAY + 2);
    localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PAY);
    localparam logic [CW-1:0] CNT_CFG = CW'(CFG_BYTES);

    frame_st_e     st;
    logic [CW-1:0] cnt;
    logic          take;
    logic          ends;
    logic          bad_end;
    logic          fwd;

    // Decode this cycle's strobes against the frame state.
    always_comb begin
        take         = !fe_start && !fe_stop && fe_byte_vld;
        ends         = !fe_start && fe_stop;
        rd_start     = fe_start && fe_rnw;
        rd_req       = take && (st == ST_READ);
        cfg_byte_vld = take && (st == ST_CFG) && (cnt < CNT_CFG);
        fwd          = take && (st == ST_WR) && (cnt < CNT_MAX);
        cfg_commit   = ends && (st == ST_CFG) && (cnt == CNT_CFG);
        bad_end      = ends && (((st == ST_CFG) && (cnt != CNT_CFG)) ||
                                ((st == ST_WR) && (cnt > CNT_MAX)) ||
                                (st == ST_BAD));
    end

    // Frame state and saturating payload counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else if (fe_start) begin
            st  <= fe_rnw ? ST_READ : ST_CMD;
            cnt <= '0;
        end else if (fe_stop) begin
            st  <= ST_IDLE;
        end else if (take) begin
            case (st)
                ST_CMD: begin
                    if (fe_wdata == CMD_CONFIG)     st <= ST_CFG;
                    else if (fe_wdata == CMD_WRITE) st <= ST_WR;
                    else                            st <= ST_BAD;
                end
                ST_CFG, ST_WR: begin
                    if (cnt <= CNT_MAX) cnt <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Registered strobes toward the SPI engine and the error output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_vld    <= 1'b0;
            tx_data   <= '0;
            frame_err <= 1'b0;
        end else begin
            tx_vld    <= fwd;
            frame_err <= bad_end;
            if (fwd) tx_data <= fe_wdata;
        end
    end
endmodule

// File: rtl/bcd_cfg_regs.sv
// Configuration registers: shifts configuration bytes into a shadow
// register, high byte first, and copies the shadow to the live settings
// and mask only on a commit strobe.
// Assumes the controller sends at most SET_W/8 + CS_W/8 bytes per frame.
module bcd_cfg_regs #(
    parameter int SET_W = 16,
    parameter int CS_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_byte_vld,
    input  logic [7:0]       cfg_byte,
    input  logic             cfg_commit,
    output logic [SET_W-1:0] settings,
    output logic [CS_W-1:0]  cs_mask,
    output logic             update
);
    localparam int SH_W = SET_W + CS_W;

    logic [SH_W-1:0] shadow;

    // Collect configuration bytes, first byte ending up most significant.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow <= '0;
        else if (cfg_byte_vld) shadow <= {shadow[SH_W-9:0], cfg_byte};
    end

    // Commit the shadow to the live registers at frame stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settings <= '0;
            cs_mask  <= '0;
            update   <= 1'b0;
        end else begin
            update <= cfg_commit;
            if (cfg_commit) begin
                settings <= shadow[SH_W-1:CS_W];
                cs_mask  <= shadow[CS_W-1:0];
            end
        end
    end
endmodule

// File: rtl/bcd_capture_buf.sv
// Capture buffer: stores bytes from the SPI engine in arrival order and
// serves them to read frames. A request at or past the read length
// returns the fill byte. A commit rewinds the write pointer; a read
// frame start rewinds the read pointer.
// Assumes DEPTH equals the largest value of the read length field.
module bcd_capture_buf
    import bcd_pkg::*;
#(
    parameter int DEPTH = 63,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_clear,
    input  logic             cap_vld,
    input  logic [7:0]       cap_data,
    input  logic             rd_start,
    input  logic             rd_req,
    input  logic [LEN_W-1:0] rd_len,
    output logic [7:0]       rd_data
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_END = PW'(DEPTH);

    logic [7:0]    mem [0:DEPTH-1];
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic          in_len;

    // Track the capture position; a commit starts a new capture run.
    always_ff @(posedge clk) begin
        if (!rst_n) wptr <= '0;
        else if (wr_clear) wptr <= '0;
        else if (cap_vld && (wptr < PTR_END)) wptr <= wptr + 1'b1;
    end

    // Store each captured byte in the next free slot.
    always_ff @(posedge clk) begin
        if (cap_vld && !wr_clear && (wptr < PTR_END)) mem[wptr] <= cap_data;
    end

    // A request is served from the buffer only below the read length.
    always_comb begin
        in_len = ({{(PW > LEN_W ? PW - LEN_W : 0){1'b0}}, rd_len} > PW'(rptr)) &&
                 (rptr < PTR_END);
    end

    // Serve read requests and advance the read pointer (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr    <= '0;
            rd_data <= FILL_BYTE;
        end else if (rd_start) begin
            rptr <= '0;
        end else if (rd_req) begin
            rd_data <= in_len ? mem[rptr] : FILL_BYTE;
            if (rptr < PTR_END) rptr <= rptr + 1'b1;
        end
    end
endmodule

// File: rtl/bridge_cmd_decoder.sv
// Top of the bridge command decoder: joins the frame controller, the
// configuration registers and the capture buffer. The read length is
// taken from the committed settings word.
// Assumes a front-end that delivers one-cycle strobes.
module bridge_cmd_decoder #(
    parameter int MAX_PAYLOAD = 62,
    parameter int SET_W       = 16,
    parameter int CS_W        = 16,
    parameter int LEN_LSB     = 10,
    parameter int LEN_W       = 6,
    parameter int HOLD_BIT    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fe_start,
    input  logic             fe_stop,
    input  logic             fe_rnw,
    input  logic             fe_byte_vld,
    input  logic [7:0]       fe_wdata,
    output logic [7:0]       rd_data,
    output logic             spi_tx_vld,
    output logic [7:0]       spi_tx_data,
    input  logic             cap_vld,
    input  logic [7:0]       cap_data,
    output logic [SET_W-1:0] cfg_settings,
    output logic [CS_W-1:0]  cs_sel,
    output logic             cs_release,
    output logic             cfg_update,
    output logic             frame_err
);
    localparam int CFG_BYTES = (SET_W + CS_W) / 8;
    localparam int CAP_DEPTH = (1 << LEN_W) - 1;

    logic             cfg_byte_vld;
    logic             cfg_commit;
    logic             rd_start;
    logic             rd_req;
    logic [LEN_W-1:0] rd_len;

    // Expose the read length field and the chip-select hold control.
    always_comb begin
        rd_len     = cfg_settings[LEN_LSB +: LEN_W];
        cs_release = cfg_settings[HOLD_BIT];
    end

    bcd_frame_ctl #(
        .MAX_PAY   (MAX_PAYLOAD),
        .CFG_BYTES (CFG_BYTES)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fe_start     (fe_start),
        .fe_stop      (fe_stop),
        .fe_rnw       (fe_rnw),
        .fe_byte_vld  (fe_byte_vld),
        .fe_wdata     (fe_wdata),
        .cfg_byte_vld (cfg_byte_vld),
        .cfg_commit   (cfg_commit),
        .rd_start     (rd_start),
        .rd_req       (rd_req),
        .tx_vld       (spi_tx_vld),
        .tx_data      (spi_tx_data),
        .frame_err    (frame_err)
    );

    bcd_cfg_regs #(
        .SET_W (SET_W),
        .CS_W  (CS_W)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_byte_vld (cfg_byte_vld),
        .cfg_byte     (fe_wdata),
        .cfg_commit   (cfg_commit),
        .settings     (cfg_settings),
        .cs_mask      (cs_sel),
        .update       (cfg_update)
    );

    bcd_capture_buf #(
        .DEPTH (CAP_DEPTH),
        .LEN_W (LEN_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_clear (cfg_commit),
        .cap_vld  (cap_vld),
        .cap_data (cap_data),
        .rd_start (rd_start),
        .rd_req   (rd_req),
        .rd_len   (rd_len),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/bcd_checker.sv
// Property checker for the bridge command decoder, attached by bind.
// Assumes the same payload limit as the decoder it watches.
module bcd_checker #(
    parameter int MAX_PAY = 62
) (
    input logic        clk,
    input logic        rst_n,
    input logic        fe_start,
    input logic        fe_stop,
    input logic        fe_byte_vld,
    input logic        spi_tx_vld,
    input logic [15:0] cfg_settings,
    input logic [15:0] cs_sel,
    input logic        cfg_update,
    input logic        frame_err
);
    logic [7:0] tx_in_frame;

    // Count forwarded bytes since the latest frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_in_frame <= '0;
        else if (fe_start) tx_in_frame <= '0;
        else if (spi_tx_vld && tx_in_frame != 8'hFF) tx_in_frame <= tx_in_frame + 1'b1;
    end

    AST_TX_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        spi_tx_vld |-> $past(fe_byte_vld)); // R2
    AST_TX_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_in_frame <= 8'(MAX_PAY)); // R3
    AST_CFG_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_settings != $past(cfg_settings) || cs_sel != $past(cs_sel)) |-> $past(fe_stop)); // R7
    AST_ERR_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(fe_stop)); // R5
    AST_ERR_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_err && cfg_update)); // R4
endmodule

bind bridge_cmd_decoder bcd_checker #(.MAX_PAY(MAX_PAYLOAD)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fe_start     (fe_start),
    .fe_stop      (fe_stop),
    .fe_byte_vld  (fe_byte_vld),
    .spi_tx_vld   (spi_tx_vld),
    .cfg_settings (cfg_settings),
    .cs_sel       (cs_sel),
    .cfg_update   (cfg_update),
    .frame_err    (frame_err)
);

// File: tb/bridge_cmd_decoder_tb.sv
// Directed bench for the bridge command decoder: one task per scenario.
module bridge_cmd_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fe_start = 1'b0;
    logic        fe_stop = 1'b0;
    logic        fe_rnw = 1'b0;
    logic        fe_byte_vld = 1'b0;
    logic [7:0]  fe_wdata = 8'h00;
    logic        cap_vld = 1'b0;
    logic [7:0]  cap_data = 8'h00;
    logic [7:0]  rd_data;
    logic        spi_tx_vld;
    logic [7:0]  spi_tx_data;
    logic [15:0] cfg_settings;
    logic [15:0] cs_sel;
    logic        cs_release;
    logic        cfg_update;
    logic        frame_err;

    int n_checks = 0;
    int n_errors = 0;
    int tx_n = 0;
    int upd_n = 0;
    int err_n = 0;
    logic [7:0] tx_log [0:255];

    always #4 clk = ~clk;

    bridge_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .fe_start(fe_start), .fe_stop(fe_stop),
        .fe_rnw(fe_rnw), .fe_byte_vld(fe_byte_vld), .fe_wdata(fe_wdata),
        .rd_data(rd_data), .spi_tx_vld(spi_tx_vld), .spi_tx_data(spi_tx_data),
        .cap_vld(cap_vld), .cap_data(cap_data), .cfg_settings(cfg_settings),
        .cs_sel(cs_sel), .cs_release(cs_release), .cfg_update(cfg_update),
        .frame_err(frame_err)
    );

    // Log pulses away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_tx_vld) begin
                tx_log[tx_n[7:0]] = spi_tx_data;
                tx_n = tx_n + 1;
            end
            if (cfg_update) upd_n = upd_n + 1;
            if (frame_err) err_n = err_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic f_start(input bit rnw);
        fe_start = 1'b1; fe_rnw = rnw; tick(); fe_start = 1'b0;
    endtask

    task automatic f_byte(input logic [7:0] b);
        fe_byte_vld = 1'b1; fe_wdata = b; tick(); fe_byte_vld = 1'b0;
    endtask

    task automatic f_stop();
        fe_stop = 1'b1; tick(); fe_stop = 1'b0;
    endtask

    task automatic load_cfg(input logic [15:0] s, input logic [15:0] m);
        f_start(1'b0);
        f_byte(8'h03);
        f_byte(s[15:8]); f_byte(s[7:0]); f_byte(m[15:8]); f_byte(m[7:0]);
        f_stop();
        tick();
    endtask

    task automatic t_reset();
        check(cfg_settings == 16'h0, "R1 settings", cfg_settings, 0);
        check(cs_sel == 16'h0, "R1 cs_sel", cs_sel, 0);
        check(rd_data == 8'hFF, "R1 rd_data", rd_data, 8'hFF);
        check(!cs_release && !spi_tx_vld && !cfg_update && !frame_err, "R1 strobes",
              {cs_release, spi_tx_vld, cfg_update, frame_err}, 0);
    endtask

    task automatic t_write3();
        int base = tx_n;
        int eb = err_n;
        f_start(1'b0); f_byte(8'h04);
        f_byte(8'h5A);
        check(spi_tx_vld && spi_tx_data == 8'h5A, "R2 next-cycle byte", spi_tx_data, 8'h5A);
        f_byte(8'hC3); f_byte(8'h00);
        f_stop(); tick();
        check(tx_n - base == 3, "R2 count", tx_n - base, 3);
        check(tx_log[base[7:0]] == 8'h5A && tx_log[8'(base + 1)] == 8'hC3 &&
              tx_log[8'(base + 2)] == 8'h00, "R2 order", tx_log[8'(base + 1)], 8'hC3);
        check(err_n == eb, "R2 no error", err_n - eb, 0);
    endtask

    task automatic t_config();
        int ub = upd_n;
        f_start(1'b0); f_byte(8'h03);
        f_byte(8'h0C); f_byte(8'h20); f_byte(8'h80); f_byte(8'h01);
        check(cfg_settings == 16'h0 && cs_sel == 16'h0, "R7 before stop", cfg_settings, 0);
        f_stop();
        check(cfg_settings == 16'h0C20, "R4 settings", cfg_settings, 16'h0C20);
        check(cs_sel == 16'h8001, "R4 cs_sel", cs_sel, 16'h8001);
        check(cfg_update, "R4 update pulse", cfg_update, 1);
        check(cs_release == 1'b1, "R10 release set", cs_release, 1);
        tick();
        check(upd_n - ub == 1, "R4 single update", upd_n - ub, 1);
    endtask

    task automatic t_bad_cfg(input int nbytes);
        int eb = err_n;
        int ub = upd_n;
        f_start(1'b0); f_byte(8'h03);
        for (int i = 0; i < nbytes; i++) f_byte(8'h11);
        f_stop(); tick();
        check(err_n - eb == 1, "R5 error", err_n - eb, 1);
        check(upd_n == ub, "R5 no update", upd_n - ub, 0);
        check(cfg_settings == 16'h0C20 && cs_sel == 16'h8001, "R5 unchanged", cfg_settings, 16'h0C20);
    endtask

    task automatic t_unknown();
        int eb = err_n;
        int base = tx_n;
        f_start(1'b0); f_byte(8'h07); f_byte(8'h99); f_byte(8'h98);
        f_stop(); tick();
        check(err_n - eb == 1, "R6 error", err_n - eb, 1);
        check(tx_n == base, "R6 no forward", tx_n - base, 0);
        check(cfg_settings == 16'h0C20, "R6 cfg unchanged", cfg_settings, 16'h0C20);
    endtask

    task automatic t_overflow(input int nbytes, input int exp_err);
        int eb = err_n;
        int base = tx_n;
        f_start(1'b0); f_byte(8'h04);
        for (int i = 0; i < nbytes; i++) f_byte(8'(i + 1));
        f_stop(); tick();
        check(tx_n - base == 62, "R3 forwarded count", tx_n - base, 62);
        check(tx_log[8'(base + 61)] == 8'd62, "R3 last byte", tx_log[8'(base + 61)], 62);
        check(err_n - eb == exp_err, "R3 error", err_n - eb, exp_err);
    endtask

    task automatic t_restart();
        int eb = err_n;
        int ub = upd_n;
        f_start(1'b0); f_byte(8'h03); f_byte(8'hAB); f_byte(8'hCD);
        f_start(1'b0); f_byte(8'h04);
        f_stop(); tick();
        check(upd_n == ub && cfg_settings == 16'h0C20, "R7 abandoned", cfg_settings, 16'h0C20);
        check(err_n == eb, "R7 no error", err_n - eb, 0);
    endtask

    task automatic t_read();
        logic [7:0] exp [0:4];
        exp[0] = 8'hA1; exp[1] = 8'hA2; exp[2] = 8'hA3; exp[3] = 8'hFF; exp[4] = 8'hFF;
        load_cfg(16'h0C00, 16'h0004);
        check(cs_release == 1'b0 && cs_sel[2], "R10 hold and select", cs_release, 0);
        for (int i = 0; i < 4; i++) begin
            cap_vld = 1'b1; cap_data = 8'(8'hA1 + i); tick();
        end
        cap_vld = 1'b0;
        f_start(1'b1);
        for (int i = 0; i < 5; i++) begin
            f_byte(8'h00);
            if (i < 3) check(rd_data == exp[i], "R8 read byte", rd_data, exp[i]);
            else       check(rd_data == exp[i], "R9 past length", rd_data, exp[i]);
        end
        f_stop(); tick();
    endtask

    task automatic t_empty();
        int eb = err_n;
        int base = tx_n;
        f_start(1'b0); f_stop(); tick();
        f_start(1'b0); f_byte(8'h04); f_stop(); tick();
        check(err_n == eb && tx_n == base, "R11 empty frames", err_n - eb, 0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_write3();
        t_config();
        t_bad_cfg(3);
        t_bad_cfg(5);
        t_unknown();
        t_overflow(64, 1);
        t_overflow(62, 0);
        t_restart();
        t_read();
        t_empty();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule